// File: doc/BRIEF.md
# Oversampled Serial ADC Word Receiver

This block reads conversion results from a serial ADC whose echoed data clock arrives on a pin that cannot feed a clock network. No flip-flop is ever clocked by that echo. A faster system clock samples both the echoed clock and the serial data line as ordinary data. Each passes through a two-flip-flop synchronizer. A rising-edge detector on the synchronized echo then yields a one-cycle strobe, and each strobe shifts the current data bit into a word register.

The block also produces the serial clock sent to the converter, and a frame signal that is high for the length of each read burst. The serial clock runs only inside a burst and rests low between bursts. A fallback mode ignores the echo. In that mode, data is taken at the block's own serial-clock rising edges, delayed to line up with the data synchronizer. A finished word is reported with a single-cycle valid pulse.

Top module: `adc_serial_rx`

## Requirements
- R1: In echo mode (`fallback_sel`=0 at start), the returned clock is sampled through a two-stage synchronizer, and each rising edge of the synchronized copy captures one bit. A word is received correctly when the echo and the data lag `sck_out` by any equal delay of 0 to 3 system cycles.
- R2: `sck_out` is low whenever `frame_out` is low. Between bursts both stay low.
- R3: A `start` pulse while idle raises `frame_out` on the next cycle and produces exactly WIDTH rising edges on `sck_out`, each high phase lasting SCK_HALF system cycles, before `frame_out` falls.
- R4: A `start` pulse during a burst is ignored: the burst still has exactly WIDTH serial clock pulses and produces exactly one word.
- R5: Bits are assembled MSB first: the first captured bit lands in `word_out[WIDTH-1]` and the last in `word_out[0]`.
- R6: `out_valid` is high for exactly one cycle per word, and `word_out` holds that word while `out_valid` is high.
- R7: In fallback mode (`fallback_sel`=1 at start), bits are captured at the block's own serial-clock rising edges. The returned clock input has no effect: a held-low echo still yields the correct word.
- R8: The mode is latched when a burst is accepted. Changing `fallback_sel` during a burst does not change how that burst is captured.
- R9: After synchronous reset, `sck_out`, `frame_out`, `out_valid` and `word_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Conversion read request, one cycle |
| fallback_sel | input | 1 | 0: echo-strobe capture, 1: own-clock capture |
| ret_clk_in | input | 1 | Echoed data clock from the ADC, sampled as data |
| sdo_in | input | 1 | Serial data from the ADC |
| sck_out | output | 1 | Burst serial clock to the ADC |
| frame_out | output | 1 | High during a read burst |
| word_out | output | WIDTH | Last completed word |
| out_valid | output | 1 | One-cycle pulse when a word completes |

## Verification
A bit counter out of step with the burst shows up as a word shifted by one position, or as a valid pulse that arrives late or not at all. Both are visible at `out_valid` within a few cycles after the burst ends. A fault in the serial clock divider appears on the pins within one burst, as a high phase of the wrong length or the wrong number of pulses. A synchronizer whose depth does not match the fallback delay captures neighbouring bits, so every word in that mode comes back corrupted.

// File: rtl/adc_rx_pkg.sv
package adc_rx_pkg;
    typedef enum logic {
        CAP_ECHO     = 1'b0,
        CAP_FALLBACK = 1'b1
    } cap_mode_e;
endpackage

// File: rtl/adc_rx_sync.sv
module adc_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/adc_rx_sck_gen.sv
module adc_rx_sck_gen #(
    parameter int WIDTH    = 16,
    parameter int SCK_HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic accept,
    output logic sck,
    output logic frame,
    output logic sck_rise
);
    localparam int DIV_W = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
    localparam int CNT_W = $clog2(WIDTH + 1);

    typedef struct packed {
        logic             frame;
        logic             sck;
        logic             rise;
        logic [DIV_W-1:0] div;
        logic [CNT_W-1:0] pulses;
    } gen_t;

    gen_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.rise = 1'b0;
        if (!st_q.frame) begin
            if (start) begin
                st_d.frame  = 1'b1;
                st_d.sck    = 1'b0;
                st_d.div    = '0;
                st_d.pulses = '0;
            end
        end else if (st_q.div == DIV_W'(SCK_HALF - 1)) begin
            st_d.div = '0;
            st_d.sck = !st_q.sck;
            if (!st_q.sck) begin
                st_d.rise = 1'b1;
            end else if (st_q.pulses == CNT_W'(WIDTH - 1)) begin
                st_d.frame  = 1'b0;
                st_d.pulses = '0;
            end else begin
                st_d.pulses = st_q.pulses + 1'b1;
            end
        end else begin
            st_d.div = st_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign accept   = start && !st_q.frame;
    assign sck      = st_q.sck;
    assign frame    = st_q.frame;
    assign sck_rise = st_q.rise;
endmodule

// File: rtl/adc_rx_shift.sv
module adc_rx_shift #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             strobe,
    input  logic             bit_in,
    output logic [WIDTH-1:0] word,
    output logic             valid
);
    localparam int CNT_W = $clog2(WIDTH + 1);

    typedef struct packed {
        logic [WIDTH-1:0] sr;
        logic [WIDTH-1:0] word;
        logic [CNT_W-1:0] cnt;
        logic             armed;
        logic             valid;
    } shf_t;

    shf_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (clear) begin
            st_d.armed = 1'b1;
            st_d.cnt   = '0;
        end else if (st_q.armed && strobe) begin
            st_d.sr = {st_q.sr[WIDTH-2:0], bit_in};
            if (st_q.cnt == CNT_W'(WIDTH - 1)) begin
                st_d.word  = {st_q.sr[WIDTH-2:0], bit_in};
                st_d.valid = 1'b1;
                st_d.armed = 1'b0;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign word  = st_q.word;
    assign valid = st_q.valid;
endmodule

// File: rtl/adc_serial_rx.sv
module adc_serial_rx #(
    parameter int WIDTH       = 16,
    parameter int SCK_HALF    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             fallback_sel,
    input  logic             ret_clk_in,
    input  logic             sdo_in,
    output logic             sck_out,
    output logic             frame_out,
    output logic [WIDTH-1:0] word_out,
    output logic             out_valid
);
    import adc_rx_pkg::*;

    logic ret_s, sdo_s, accept, sck_rise, strobe;

    // Equal depth on both lines keeps echo and data aligned.
    adc_rx_sync #(.STAGES(SYNC_STAGES)) u_sync_ret (
        .clk(clk), .rst(rst), .d(ret_clk_in), .q(ret_s));
    adc_rx_sync #(.STAGES(SYNC_STAGES)) u_sync_sdo (
        .clk(clk), .rst(rst), .d(sdo_in), .q(sdo_s));

    adc_rx_sck_gen #(.WIDTH(WIDTH), .SCK_HALF(SCK_HALF)) u_gen (
        .clk(clk), .rst(rst), .start(start), .accept(accept),
        .sck(sck_out), .frame(frame_out), .sck_rise(sck_rise));

    typedef struct packed {
        logic                   ret_prev;
        logic [SYNC_STAGES-1:0] rise_dly;
        cap_mode_e              mode;
    } top_t;

    top_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.ret_prev = ret_s;
        st_d.rise_dly = {st_q.rise_dly[SYNC_STAGES-2:0], sck_rise};
        if (accept) st_d.mode = cap_mode_e'(fallback_sel);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.ret_prev <= 1'b0;
            st_q.rise_dly <= '0;
            st_q.mode     <= CAP_ECHO;
        end else begin
            st_q <= st_d;
        end
    end

    assign strobe = (st_q.mode == CAP_FALLBACK) ? st_q.rise_dly[SYNC_STAGES-1]
                                                : (ret_s && !st_q.ret_prev);

    adc_rx_shift #(.WIDTH(WIDTH)) u_shift (
        .clk(clk), .rst(rst), .clear(accept), .strobe(strobe),
        .bit_in(sdo_s), .word(word_out), .valid(out_valid));
endmodule

// File: rtl/adc_serial_rx_chk.sv
module adc_serial_rx_chk #(
    parameter int WIDTH = 16
) (
    input logic clk,
    input logic rst,
    input logic start,
    input logic sck_out,
    input logic frame_out,
    input logic out_valid
);
    localparam int CW = $clog2(WIDTH + 1) + 1;
    logic          sck_prev_q;
    logic [CW-1:0] rise_cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_prev_q <= 1'b0;
            rise_cnt_q <= '0;
        end else begin
            sck_prev_q <= sck_out;
            if (!frame_out)                rise_cnt_q <= '0;
            else if (sck_out && !sck_prev_q) rise_cnt_q <= rise_cnt_q + 1'b1;
        end
    end

    // R2
    sck_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_out |-> !sck_out);
    // R3
    frame_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_out) |-> $past(start));
    // R3
    pulse_total_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(frame_out) |-> rise_cnt_q == CW'(WIDTH));
    // R6
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);
    // R9
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (!sck_out && !frame_out && !out_valid));
endmodule

bind adc_serial_rx adc_serial_rx_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst(rst), .start(start), .sck_out(sck_out),
    .frame_out(frame_out), .out_valid(out_valid));

// File: tb/adc_serial_rx_test.sv
module adc_serial_rx_test;
    localparam int WIDTH = 16;
    localparam int HALF  = 2;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0, fallback_sel = 1'b0;
    logic ret_clk_in = 1'b0, sdo_in = 1'b0;
    logic sck_out, frame_out, out_valid;
    logic [WIDTH-1:0] word_out;

    adc_serial_rx #(.WIDTH(WIDTH), .SCK_HALF(HALF), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst(rst), .start(start), .fallback_sel(fallback_sel),
        .ret_clk_in(ret_clk_in), .sdo_in(sdo_in), .sck_out(sck_out),
        .frame_out(frame_out), .word_out(word_out), .out_valid(out_valid));

    always #2 clk = !clk;

    int tests = 0, fails = 0;
    bit done = 0;
    int dly = 0;
    bit tie_ret = 0;
    logic [WIDTH-1:0] adc_word = '0;

    // Monitor state
    int rise_cnt = 0, valid_cnt = 0, valid_run = 0, long_valid = 0;
    int high_len = 0, bad_phase = 0, idle_sck = 0;
    logic [WIDTH-1:0] got_word = '0;

    function automatic int exp_pulses();
        return WIDTH;
    endfunction

    function automatic logic [WIDTH-1:0] exp_word(input logic [WIDTH-1:0] w);
        return w; // MSB-first sent, MSB-first assembled
    endfunction

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ADC model: drives the echo and data lines with a common delay.
    initial begin
        logic sck_h [8];
        logic sdo_h [8];
        logic sdo_int = 1'b0, sck_prev = 1'b0, frm_prev = 1'b0;
        int idx = 0;
        for (int i = 0; i < 8; i++) begin sck_h[i] = 0; sdo_h[i] = 0; end
        forever begin
            @(posedge clk); #1;
            if (frame_out && !frm_prev) begin
                idx = WIDTH - 1; sdo_int = adc_word[idx];
            end else if (!sck_out && sck_prev && idx > 0) begin
                idx--; sdo_int = adc_word[idx];
            end
            for (int i = 7; i > 0; i--) begin sck_h[i] = sck_h[i-1]; sdo_h[i] = sdo_h[i-1]; end
            sck_h[0] = sck_out; sdo_h[0] = sdo_int;
            ret_clk_in = tie_ret ? 1'b0 : sck_h[dly];
            sdo_in     = sdo_h[dly];
            sck_prev = sck_out; frm_prev = frame_out;
        end
    end

    // Output monitor
    initial begin
        logic mprev = 1'b0;
        forever begin
            @(posedge clk); #2;
            if (!rst) begin
                if (!frame_out && sck_out) idle_sck++;
                if (sck_out && !mprev) rise_cnt++;
                if (sck_out) high_len++;
                else begin
                    if (mprev && high_len != HALF) bad_phase++;
                    high_len = 0;
                end
                if (out_valid) begin
                    valid_cnt++; valid_run++; got_word = word_out;
                    if (valid_run > 1) long_valid++;
                end else valid_run = 0;
            end
            mprev = sck_out;
        end
    end

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic run_conv(input logic [WIDTH-1:0] w, input bit fb, input int d,
                            input bit tie, input bit mid_start, input bit mid_mode,
                            input string req);
        int wait_n = 0;
        adc_word = w; fallback_sel = fb; dly = d; tie_ret = tie;
        rise_cnt = 0; valid_cnt = 0; long_valid = 0; bad_phase = 0; idle_sck = 0;
        pulse_start();
        if (mid_start || mid_mode) begin
            repeat (10) @(negedge clk);
            if (mid_mode) fallback_sel = !fb;
            if (mid_start) pulse_start();
        end
        while (valid_cnt == 0 && wait_n < 400) begin @(negedge clk); wait_n++; end
        repeat (20) @(negedge clk);
        check({req, " word"}, int'(got_word), int'(exp_word(w)));
        check("R3 pulse count", rise_cnt, exp_pulses());
        check("R3 high phase length", bad_phase, 0);
        check("R6 single valid per word", valid_cnt, 1);
        check("R6 valid width one cycle", long_valid, 0);
        check("R2 sck idle outside frame", idle_sck + int'(sck_out) + int'(frame_out), 0);
        fallback_sel = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (4) @(negedge clk);
        // R9 reset state
        check("R9 sck", int'(sck_out), 0);
        check("R9 frame", int'(frame_out), 0);
        check("R9 valid", int'(out_valid), 0);
        check("R9 word", int'(word_out), 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // Directed corners, echo mode (R1, R5)
        run_conv(16'h8000, 1'b0, 0, 1'b0, 1'b0, 1'b0, "R5 msb only");
        run_conv(16'h0001, 1'b0, 3, 1'b0, 1'b0, 1'b0, "R5 lsb only");
        run_conv(16'hFFFF, 1'b0, 2, 1'b0, 1'b0, 1'b0, "R1 all ones");
        run_conv(16'h0000, 1'b0, 1, 1'b0, 1'b0, 1'b0, "R1 all zeros");
        // Start during burst ignored (R4)
        run_conv(16'hA5C3, 1'b0, 1, 1'b0, 1'b1, 1'b0, "R4 start in burst");
        // Fallback with echo held low (R7)
        run_conv(16'h5A3C, 1'b1, 0, 1'b1, 1'b0, 1'b0, "R7 fallback");
        run_conv(16'h8001, 1'b1, 0, 1'b1, 1'b0, 1'b0, "R7 fallback edges");
        // Mode flip mid-burst, echo lag that fallback cannot handle (R8)
        run_conv(16'hC3A5, 1'b0, 3, 1'b0, 1'b0, 1'b1, "R8 mode latched");

        // Random words (R1 echo with random lag, R7 fallback)
        for (int k = 0; k < 24; k++) begin
            logic [WIDTH-1:0] w;
            w = WIDTH'($urandom);
            if (k % 4 == 3) run_conv(w, 1'b1, 0, 1'b1, 1'b0, 1'b0, "R7 random fallback");
            else            run_conv(w, 1'b0, int'($urandom % 4), 1'b0, 1'b0, 1'b0, "R1 random echo");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule